// File: doc/BRIEF.md
# Magnitude-Based Input Prescaler

This block sits in front of a shift-and-add angle engine. It accepts a pair of signed fixed-point coordinates and forms a cheap, multiplier-free estimate of the vector length. The estimate is the larger absolute value plus half of the smaller one. It then sorts that estimate into one of a configurable number of power-of-two magnitude bands. Short vectors get a left shift that depends on their band. The shift moves them out to the two outermost bands, where the angle engine loses little accuracy. The datapath never gets wider: the shift chosen for each band is small enough that the scaled coordinates always fit in the input width.

Each accepted input produces one registered result one clock later. The result holds both scaled coordinates, a one-hot band vector and the shift amount that was applied. The same shift is applied to both coordinates, so the angle of the vector does not change.

Top module: `vec_prescaler`

## Requirements
- R1: The magnitude estimate is max(|x|,|y|) + floor(min(|x|,|y|)/2), held as a W-bit unsigned value; for equal absolute coordinates it is |x| + floor(|x|/2).
- R2: The estimate is never below max(|x|,|y|), and equals |x| exactly when y is zero (and |y| when x is zero).
- R3: Band k (1 ≤ k < NBANDS) is selected when the highest set bit of the estimate is at position W-k; out_band bit k-1 marks band k, and exactly one bit of out_band is set in every valid result.
- R4: An estimate with no set bit at positions W-1 down to W-NBANDS+1, including the all-zero vector, is placed in band NBANDS (out_band bit NBANDS-1).
- R5: out_shift is 0 for bands 1 and 2 and k-2 for band k ≥ 3, so its largest value is NBANDS-2.
- R6: out_x and out_y equal in_x and in_y multiplied by 2^out_shift, always representable in W-bit two's complement with no overflow; an all-zero input gives all-zero coordinates.
- R7: out_valid is in_valid delayed by exactly one clock, and the data outputs of a valid result reflect the inputs sampled at that same edge.
- R8: While in_valid is low, out_x, out_y, out_band and out_shift keep their last values.
- R9: While rst_n is low at a clock edge, every output is cleared to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Input coordinates are valid this cycle |
| in_x | input | W | Signed x coordinate |
| in_y | input | W | Signed y coordinate |
| out_valid | output | 1 | Registered result is valid |
| out_x | output | W | Scaled signed x coordinate |
| out_y | output | W | Scaled signed y coordinate |
| out_band | output | NBANDS | One-hot magnitude band, bit k-1 for band k |
| out_shift | output | SHW | Left shift applied to both coordinates |

## Verification
The hardest cases to reach from the ports are the edges of the band scheme. One is the catch-all band for estimates below the lowest tracked bit, where the largest shift is applied. Another is the most negative coordinate sitting at the top band with no shift, and another is the exact point where the estimate crosses a power of two. The bench runs a narrow configuration (8-bit coordinates, six bands) and sweeps every x,y pair back to back, one per clock. This reaches all these points and every pair of equal absolute values. Each expected band, shift and scaled value is computed arithmetically in the bench.

// File: rtl/prescale_pkg.sv
// Package: shared helpers for the magnitude prescaler.
// Assumes bands are numbered from 1 (outermost) upward.
package prescale_pkg;

    // Left shift applied to a vector that lies in band k.
    function automatic int band_shift(input int k);
        return (k >= 3) ? (k - 2) : 0;
    endfunction

endpackage

// File: rtl/coord_abs.sv
// Module: coord_abs
// Absolute value of one signed coordinate, returned as a W-bit unsigned value.
// Assumes two's complement; the most negative input maps to 2^(W-1), which
// still fits in W unsigned bits.
module coord_abs #(
    parameter int W = 14
) (
    input  logic [W-1:0] coord,
    output logic [W-1:0] mag
);

    // Negate when the sign bit is set.
    always_comb begin
        if (coord[W-1]) begin
            mag = ~coord + 1'b1;
        end else begin
            mag = coord;
        end
    end

endmodule

// File: rtl/mag_est.sv
// Module: mag_est
// Multiplier-free length estimate: larger magnitude plus half the smaller.
// Assumes both inputs are at most 2^(W-1), so the sum stays below 2^W.
module mag_est #(
    parameter int W = 14
) (
    input  logic [W-1:0] mag_a,
    input  logic [W-1:0] mag_b,
    output logic [W-1:0] larger,
    output logic [W-1:0] est
);

    logic [W-1:0] smaller;

    // Compare and steer the two magnitudes.
    always_comb begin
        if (mag_a >= mag_b) begin
            larger  = mag_a;
            smaller = mag_b;
        end else begin
            larger  = mag_b;
            smaller = mag_a;
        end
    end

    // Add the larger value to the smaller one shifted right by one.
    always_comb begin
        est = larger + (smaller >> 1);
    end

endmodule

// File: rtl/band_classify.sv
// Module: band_classify
// Turns the estimate into one-hot band flags with a leading-one chain and
// encodes the matching shift. Band k marks the first set bit at W-k; the last
// band also catches all smaller estimates, including zero.
// Assumes 2 <= NBANDS <= W+1.
module band_classify
    import prescale_pkg::*;
#(
    parameter int W      = 14,
    parameter int NBANDS = 9,
    parameter int SHW    = 3
) (
    input  logic [W-1:0]      est,
    output logic [NBANDS-1:0] band,
    output logic [SHW-1:0]    shift
);

    // seen[i] is set when any estimate bit above position W-1-i is one.
    logic [NBANDS-1:0] seen;

    assign seen[0] = 1'b0;

    generate
        for (genvar i = 0; i < NBANDS - 1; i++) begin : g_band
            // Propagate the leading-one indication down one bit.
            assign seen[i+1] = seen[i] | est[W-1-i];
            // Band i+1 owns the first set bit at position W-1-i.
            assign band[i]   = est[W-1-i] & ~seen[i];
        end
    endgenerate

    // The outermost-numbered band collects everything not claimed above.
    assign band[NBANDS-1] = ~seen[NBANDS-1];

    // One-hot to shift encoder: OR together the shift of the active band.
    always_comb begin
        shift = '0;
        for (int k = 0; k < NBANDS; k++) begin
            if (band[k]) begin
                shift = shift | SHW'(band_shift(k + 1));
            end
        end
    end

endmodule

// File: rtl/vec_prescaler.sv
// Module: vec_prescaler (top)
// Estimates vector length, picks a power-of-two band and left-shifts both
// coordinates by the band's amount; the result is registered (one cycle).
// Assumes 2 <= NBANDS <= W+1; the chosen shift never overflows W bits.
module vec_prescaler #(
    parameter int W      = 14,
    parameter int NBANDS = 9,
    parameter int SHW    = (NBANDS > 2) ? $clog2(NBANDS - 1) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [W-1:0]      in_x,
    input  logic [W-1:0]      in_y,
    output logic              out_valid,
    output logic [W-1:0]      out_x,
    output logic [W-1:0]      out_y,
    output logic [NBANDS-1:0] out_band,
    output logic [SHW-1:0]    out_shift
);

    localparam int MAXSH = NBANDS - 2;

    logic [1:0][W-1:0]  coord;
    logic [1:0][W-1:0]  mag;
    logic [W-1:0]       larger;
    logic [W-1:0]       est;
    logic [NBANDS-1:0]  band;
    logic [SHW-1:0]     shift;
    logic [W-1:0]       scaled_x;
    logic [W-1:0]       scaled_y;

    assign coord[0] = in_x;
    assign coord[1] = in_y;

    generate
        for (genvar c = 0; c < 2; c++) begin : g_abs
            coord_abs #(.W(W)) u_abs (
                .coord (coord[c]),
                .mag   (mag[c])
            );
        end
    endgenerate

    mag_est #(.W(W)) u_est (
        .mag_a  (mag[0]),
        .mag_b  (mag[1]),
        .larger (larger),
        .est    (est)
    );

    band_classify #(.W(W), .NBANDS(NBANDS), .SHW(SHW)) u_band (
        .est   (est),
        .band  (band),
        .shift (shift)
    );

    // Apply the same left shift to both coordinates.
    always_comb begin
        scaled_x = in_x << shift;
        scaled_y = in_y << shift;
    end

    // Valid strobe register: follows the input strobe with one cycle delay.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
        end else begin
            out_valid <= in_valid;
        end
    end

    // Result register: loads on valid input and holds otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_x     <= '0;
            out_y     <= '0;
            out_band  <= '0;
            out_shift <= '0;
        end else if (in_valid) begin
            out_x     <= scaled_x;
            out_y     <= scaled_y;
            out_band  <= band;
            out_shift <= shift;
        end
    end

    // Estimate never undercuts the larger magnitude (R2).
    p_est_ge_max_r2: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |-> (est >= larger));

    // Every valid result carries exactly one band flag (R3).
    p_onehot_band_r3: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> ($countones(out_band) == 1));

    // Shift stays within the configured range (R5).
    p_shift_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (int'(out_shift) <= MAXSH));

    // Scaling is reversible, so nothing was lost off the top (R6).
    p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> ((($signed(out_x) >>> out_shift) == $signed($past(in_x))) &&
                       (($signed(out_y) >>> out_shift) == $signed($past(in_y)))));

    // Zero vector stays zero (R6).
    p_zero_out_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_x == '0 && in_y == '0) |=> (out_x == '0 && out_y == '0));

    // One-cycle latency on the strobe (R7).
    p_latency_r7: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    // Data holds while no input is offered (R8).
    p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(out_x) && $stable(out_y) &&
                       $stable(out_band) && $stable(out_shift)));

endmodule

// File: tb/tb_vec_prescaler.sv
`timescale 1ns/1ps
// Exhaustive sweep of a narrow configuration with arithmetic expected values.
module tb_vec_prescaler;

    localparam int TW  = 8;
    localparam int TNB = 6;
    localparam int TSH = 3;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           in_valid = 1'b0;
    logic [TW-1:0]  in_x = '0;
    logic [TW-1:0]  in_y = '0;
    logic           out_valid;
    logic [TW-1:0]  out_x;
    logic [TW-1:0]  out_y;
    logic [TNB-1:0] out_band;
    logic [TSH-1:0] out_shift;

    int checks = 0;
    int failures = 0;

    always #2.5 clk = ~clk;

    vec_prescaler #(.W(TW), .NBANDS(TNB), .SHW(TSH)) dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_x      (in_x),
        .in_y      (in_y),
        .out_valid (out_valid),
        .out_x     (out_x),
        .out_y     (out_y),
        .out_band  (out_band),
        .out_shift (out_shift)
    );

    task automatic chk(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int iabs(input int v);
        return (v < 0) ? -v : v;
    endfunction

    // Estimate per R1.
    function automatic int est_of(input int x, input int y);
        int a, b;
        a = iabs(x);
        b = iabs(y);
        return (a >= b) ? a + b / 2 : b + a / 2;
    endfunction

    // Band number per R3 and R4.
    function automatic int band_of(input int e);
        for (int k = 1; k < TNB; k++) begin
            if (e >= (1 << (TW - k))) return k;
        end
        return TNB;
    endfunction

    function automatic int shift_of(input int k);
        return (k >= 3) ? k - 2 : 0;
    endfunction

    int px, py, pband, pshift;
    bit have_prev;

    task automatic check_prev();
        chk("R3/R4 band", longint'(out_band), longint'(1) << (pband - 1));
        chk("R5 shift", longint'(out_shift), longint'(pshift));
        chk("R6 x", longint'($signed(out_x)), longint'(px) * (1 << pshift));
        chk("R6 y", longint'($signed(out_y)), longint'(py) * (1 << pshift));
        chk("R7 valid", longint'(out_valid), 1);
        if (py == 0) begin
            // R2: with y zero the estimate is exactly |x|
            chk("R2 exact", longint'(band_of(est_of(px, py))), longint'(band_of(iabs(px))));
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R9 reset state
        chk("R9 valid", longint'(out_valid), 0);
        chk("R9 x", longint'(out_x), 0);
        chk("R9 y", longint'(out_y), 0);
        chk("R9 band", longint'(out_band), 0);
        chk("R9 shift", longint'(out_shift), 0);
        rst_n = 1'b1;
        have_prev = 1'b0;
        for (int x = -(1 << (TW - 1)); x < (1 << (TW - 1)); x++) begin
            for (int y = -(1 << (TW - 1)); y < (1 << (TW - 1)); y++) begin
                @(negedge clk);
                if (have_prev) check_prev();
                in_valid = 1'b1;
                in_x = TW'(x);
                in_y = TW'(y);
                px = x;
                py = y;
                pband = band_of(est_of(x, y));
                pshift = shift_of(pband);
                have_prev = 1'b1;
            end
        end
        @(negedge clk);
        check_prev();
        // R8 hold with changing inputs while strobe is low
        in_valid = 1'b0;
        for (int i = 0; i < 3; i++) begin
            in_x = TW'(i + 1);
            in_y = TW'(i + 2);
            @(negedge clk);
            chk("R7 valid low", longint'(out_valid), 0);
            chk("R8 hold x", longint'($signed(out_x)), longint'(px) * (1 << pshift));
            chk("R8 hold band", longint'(out_band), longint'(1) << (pband - 1));
            chk("R8 hold shift", longint'(out_shift), longint'(pshift));
        end
        // R4 and R6: directed zero vector lands in the catch-all band
        in_valid = 1'b1;
        in_x = '0;
        in_y = '0;
        @(negedge clk);
        in_valid = 1'b0;
        chk("R4 zero band", longint'(out_band), longint'(1) << (TNB - 1));
        chk("R6 zero x", longint'(out_x), 0);
        chk("R6 zero y", longint'(out_y), 0);
        // R9 reset mid-run clears outputs
        rst_n = 1'b0;
        @(negedge clk);
        chk("R9 reclear band", longint'(out_band), 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule